// File: doc/BRIEF.md
# Functional Broadside Self-Test Controller

This block is an on-chip self-test engine for a small sequential logic core with three state flip-flops, four primary inputs and one primary output. On a start request it puts the core into its reset state. It then walks the core forward with pseudo-random input vectors, so every state the core passes through is one it can reach in normal operation. At regular points in that walk, the state the core has reached serves as the launch state for a test. The test is exactly two functional clock cycles: a launch cycle and a capture cycle. The core's response to the capture cycle is folded into a signature register.

A stall watcher guards the walk. If the input stream keeps driving the core into the same state, the watcher inverts one chosen bit of the input vector until the state moves again. This keeps the walk from collapsing onto a single synchronising state. The seed, walk length, test count, stall limit, flipped bit and expected signature are all elaboration parameters. Changing a few of them on otherwise fixed hardware produces a different set of launch states and patterns.

When the session ends, the block raises `done` and holds it. `pass` reports whether the final signature equals the expected constant. A fault-injection parameter can force one next-state net of the core stuck at one, which gives a way to show that a defect turns `pass` low.

Top module: `fbt_bist`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `busy`, `done` and `pass` are 0, `signature` is 0 and the core state is 000.
- R2: A high `start` at a clock edge while idle or done begins a session. The first cycle loads the core state with 000, loads the pattern register with SEED and clears the signature. `start` has no effect while `busy` is high.
- R3: The pattern register is a 16-bit LFSR that shifts toward the MSB. The new bit 0 equals bit15 ^ bit13 ^ bit12 ^ bit10. Its bits [3:0] form the input vector, with bit i driving core input i. It advances once per functional cycle.
- R4: The core computes next state and output from state s and input i as follows: n0 = (i0 & s1) | (i3 & ~s0); n1 = ~(i1 | s2); n2 = (s0 ^ i2) & ~i3; out = (s0 & i1) | (s2 ^ i3).
- R5: A run counter adds one on each functional cycle whose next state equals the current state, saturating at STALL_LIM, and clears on any cycle where the state changes. On a functional cycle where the counter is at least STALL_LIM, input bit FLIP_BIT is inverted before it reaches the core.
- R6: Each test takes WALK_LEN walk cycles, then one launch cycle and one capture cycle. No state is loaded before the launch cycle. One compaction cycle follows, in which the core holds. The core state carries over from one test to the next, for NUM_TESTS tests.
- R7: In the compaction cycle the signature register s becomes {s[14:0], s15^s13^s12^s10} XOR a 16-bit word. That word holds the core state after capture in bits [2:0], the capture-cycle output in bit 3, and zeros above.
- R8: `busy` is high from the cycle after `start` is accepted until `done` rises. `done` rises 1 + NUM_TESTS*(WALK_LEN+3) clock edges after the accepting edge. `done` and `signature` then hold until the next accepted start.
- R9: `pass` equals `done` AND (`signature` == GOLDEN_SIG).
- R10: With STUCK_N1 set, core next-state bit 1 is forced to 1. This yields a signature different from the fault-free one, and `pass` stays low when GOLDEN_SIG holds the fault-free value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a self-test session |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session complete, held until restart |
| pass | output | 1 | Final signature matches the expected constant |
| signature | output | 16 | Current compacted response |

## Verification
A wrong launch state, a wrong pattern step or a missed stall flip does not show up while the session runs. It shows up when `done` rises, because the final `signature` then differs from the value computed from the core equations. A slip in the walk or test counters shows up as `done` rising on the wrong cycle. Instances built with a second seed, with the stall watcher effectively disabled, and with the stuck-at fault each give their own predicted signature. Together they separate errors in the pattern source, the modifier and the core.

// File: rtl/fbt_pkg.sv
// Shared constants and controller state encoding for the broadside self-test block.
// Assumes a fixed three-flop core with four inputs and one output.
package fbt_pkg;
    localparam int PAT_W   = 16;
    localparam int CUT_NI  = 4;
    localparam int CUT_NS  = 3;
    localparam logic [PAT_W-1:0] FB_TAPS = 16'hB400; // bits 15,13,12,10

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_INIT    = 3'd1,
        ST_WALK    = 3'd2,
        ST_LAUNCH  = 3'd3,
        ST_CAPTURE = 3'd4,
        ST_COMPACT = 3'd5,
        ST_DONE    = 3'd6
    } fbt_state_e;
endpackage

// File: rtl/fbt_lfsr.sv
// Pseudo-random pattern source: Fibonacci LFSR shifting toward the MSB.
// Assumes SEED is nonzero, so the register never enters the all-zero lock state.
module fbt_lfsr #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  SEED = 16'hACE1,
    parameter logic [W-1:0]  TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] q
);
    logic fb;

    // Feedback bit is the parity of the tapped positions.
    always_comb fb = ^(q & TAPS);

    // Register update: reseed on reset or load, shift on step.
    always_ff @(posedge clk) begin
        if (!rst_n || load) q <= SEED;
        else if (step)      q <= {q[W-2:0], fb};
    end

    // R3
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) q != '0);
endmodule

// File: rtl/fbt_stall_mod.sv
// Sequence modifier: counts consecutive functional cycles in which the core state
// does not move and, once the count reaches LIM, inverts one input bit.
// Assumes LIM >= 1 and FLIP_BIT < NI.
module fbt_stall_mod #(
    parameter int NI       = 4,
    parameter int NS       = 3,
    parameter int LIM      = 1,
    parameter int FLIP_BIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [NI-1:0] vec_in,
    input  logic [NS-1:0] cur_state,
    input  logic [NS-1:0] nxt_state,
    output logic [NI-1:0] vec_out,
    output logic          flip
);
    localparam int            RW    = $clog2(LIM + 1);
    localparam logic [NI-1:0] FMASK = NI'(1) << FLIP_BIT;
    localparam logic [RW-1:0] LIMV  = RW'(LIM);

    logic [RW-1:0] run;

    // Flip decision and modified vector for the current functional cycle.
    always_comb begin
        flip    = en && (run >= LIMV);
        vec_out = flip ? (vec_in ^ FMASK) : vec_in;
    end

    // Run counter: saturating count of unchanged-state cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)            run <= '0;
        else if (en) begin
            if (nxt_state != cur_state) run <= '0;
            else if (run != LIMV)       run <= run + 1'b1;
        end
    end

    // R5
    no_flip_after_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (nxt_state != cur_state)) |=> !flip);
endmodule

// File: rtl/fbt_cut.sv
// Small sequential core under test: three state flops, four inputs, one output.
// STUCK_N1 selects a variant with next-state bit 1 stuck at one (fault injection).
module fbt_cut #(
    parameter int NI       = 4,
    parameter int NS       = 3,
    parameter bit STUCK_N1 = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          en,
    input  logic [NI-1:0] vec,
    output logic [NS-1:0] state,
    output logic [NS-1:0] nxt,
    output logic          out
);
    logic n1_good;
    logic n1_used;

    // Combinational next-state and output logic of the core.
    always_comb begin
        n1_good = ~(vec[1] | state[2]);
        nxt[0]  = (vec[0] & state[1]) | (vec[3] & ~state[0]);
        nxt[1]  = n1_used;
        nxt[2]  = (state[0] ^ vec[2]) & ~vec[3];
        out     = (state[0] & vec[1]) | (state[2] ^ vec[3]);
    end

    generate
        if (STUCK_N1) begin : g_stuck
            assign n1_used = 1'b1;
        end else begin : g_good
            assign n1_used = n1_good;
        end
    endgenerate

    // State flops: reset state on reset or init, advance on functional cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || init) state <= '0;
        else if (en)        state <= nxt;
    end

    // R6
    cut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !init) |=> $stable(state));
endmodule

// File: rtl/fbt_misr.sv
// Multiple-input signature register: shifts with LFSR feedback and XORs in a word.
module fbt_misr #(
    parameter int           W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         fold,
    input  logic [W-1:0] din,
    output logic [W-1:0] sig
);
    // Signature update: clear, or fold one response word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sig <= '0;
        else if (fold)     sig <= {sig[W-2:0], ^(sig & TAPS)} ^ din;
    end

    // R7
    misr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fold && !clr) |=> $stable(sig));
endmodule

// File: rtl/fbt_bist.sv
// Top: sequences INIT, WALK, LAUNCH, CAPTURE and COMPACT for NUM_TESTS tests and
// reports pass when the final signature matches GOLDEN_SIG.
// Assumes WALK_LEN >= 1, NUM_TESTS >= 1, STALL_LIM >= 1 and a nonzero SEED.
module fbt_bist
    import fbt_pkg::*;
#(
    parameter logic [15:0] SEED       = 16'hACE1,
    parameter int          WALK_LEN   = 6,
    parameter int          NUM_TESTS  = 8,
    parameter int          STALL_LIM  = 1,
    parameter int          FLIP_BIT   = 1,
    parameter logic [15:0] GOLDEN_SIG = 16'h0000,
    parameter bit          STUCK_N1   = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic        pass,
    output logic [15:0] signature
);
    localparam int WCW = $clog2(WALK_LEN + 1);
    localparam int TCW = $clog2(NUM_TESTS + 1);
    localparam logic [WCW-1:0] WALK_LAST = WCW'(WALK_LEN - 1);
    localparam logic [TCW-1:0] TEST_LAST = TCW'(NUM_TESTS - 1);

    fbt_state_e         st;
    logic [WCW-1:0]     walk_cnt;
    logic [TCW-1:0]     test_cnt;
    logic               cut_en;
    logic               out_q;
    logic [PAT_W-1:0]   pat;
    logic [CUT_NI-1:0]  vec_mod;
    logic [CUT_NS-1:0]  cut_state;
    logic [CUT_NS-1:0]  cut_nxt;
    logic               cut_out;
    logic               flip;
    logic [PAT_W-1:0]   resp_word;

    // Functional-cycle enable and response word built from capture results.
    always_comb begin
        cut_en    = (st == ST_WALK) || (st == ST_LAUNCH) || (st == ST_CAPTURE);
        resp_word = {{(PAT_W-CUT_NS-1){1'b0}}, out_q, cut_state};
    end

    // Controller state machine with walk and test counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            walk_cnt <= '0;
            test_cnt <= '0;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: if (start) st <= ST_INIT;
                ST_INIT: begin
                    walk_cnt <= '0;
                    test_cnt <= '0;
                    st       <= ST_WALK;
                end
                ST_WALK: begin
                    if (walk_cnt == WALK_LAST) begin
                        walk_cnt <= '0;
                        st       <= ST_LAUNCH;
                    end else begin
                        walk_cnt <= walk_cnt + 1'b1;
                    end
                end
                ST_LAUNCH:  st <= ST_CAPTURE;
                ST_CAPTURE: st <= ST_COMPACT;
                ST_COMPACT: begin
                    if (test_cnt == TEST_LAST) begin
                        st <= ST_DONE;
                    end else begin
                        test_cnt <= test_cnt + 1'b1;
                        st       <= ST_WALK;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Capture-cycle output register for compaction.
    always_ff @(posedge clk) begin
        if (!rst_n)                out_q <= 1'b0;
        else if (st == ST_CAPTURE) out_q <= cut_out;
    end

    fbt_lfsr #(.W(PAT_W), .SEED(SEED), .TAPS(FB_TAPS)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (st == ST_INIT),
        .step  (cut_en),
        .q     (pat)
    );

    fbt_stall_mod #(.NI(CUT_NI), .NS(CUT_NS), .LIM(STALL_LIM), .FLIP_BIT(FLIP_BIT)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (st == ST_INIT),
        .en        (cut_en),
        .vec_in    (pat[CUT_NI-1:0]),
        .cur_state (cut_state),
        .nxt_state (cut_nxt),
        .vec_out   (vec_mod),
        .flip      (flip)
    );

    fbt_cut #(.NI(CUT_NI), .NS(CUT_NS), .STUCK_N1(STUCK_N1)) u_cut (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (st == ST_INIT),
        .en    (cut_en),
        .vec   (vec_mod),
        .state (cut_state),
        .nxt   (cut_nxt),
        .out   (cut_out)
    );

    fbt_misr #(.W(PAT_W), .TAPS(FB_TAPS)) u_misr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st == ST_INIT),
        .fold  (st == ST_COMPACT),
        .din   (resp_word),
        .sig   (signature)
    );

    // Status outputs decoded from the controller state.
    always_comb begin
        busy = (st != ST_IDLE) && (st != ST_DONE);
        done = (st == ST_DONE);
        pass = done && (signature == GOLDEN_SIG);
    end

    // R6
    launch_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LAUNCH) |-> ($past(st) == ST_WALK));
    // R6
    capture_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPTURE) |-> ($past(st) == ST_LAUNCH));
    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(signature)));
    // R5
    flip_only_functional_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flip |-> busy);
endmodule

// File: tb/fbt_bist_tb.sv
`timescale 1ns/1ps
module fbt_bist_tb;
    localparam int          WL     = 6;
    localparam int          NT     = 8;
    localparam int          FB     = 1;
    localparam int          LIM    = 1;
    localparam int          LIMOFF = 255;
    localparam logic [15:0] SEED_A = 16'hACE1;
    localparam logic [15:0] SEED_B = 16'h1D2C;
    localparam int          LAT    = 1 + NT * (WL + 3);

    function automatic logic [15:0] step16(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Software model of one whole session, following R3..R7.
    function automatic logic [15:0] model_sig(input logic [15:0] seed, input int lim,
                                              input int stuck);
        logic [2:0]  s;
        logic [2:0]  n;
        logic [3:0]  v;
        logic [15:0] l;
        logic [15:0] m;
        logic        o;
        logic        ol;
        int          run;
        s = 3'b000; n = 3'b000; v = 4'h0; l = seed; m = 16'h0;
        o = 1'b0; ol = 1'b0; run = 0;
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < WL + 2; k++) begin
                v = l[3:0];
                if (run >= lim) v[FB] = ~v[FB];
                n[0] = (v[0] & s[1]) | (v[3] & ~s[0]);
                n[1] = (stuck != 0) ? 1'b1 : ~(v[1] | s[2]);
                n[2] = (s[0] ^ v[2]) & ~v[3];
                o    = (s[0] & v[1]) | (s[2] ^ v[3]);
                if (n == s) run = (run < lim) ? run + 1 : lim;
                else        run = 0;
                ol = o;
                s  = n;
                l  = step16(l);
            end
            m = step16(m) ^ {12'h000, ol, s};
        end
        return m;
    endfunction

    localparam logic [15:0] GOLD_A = model_sig(SEED_A, LIM, 0);
    localparam logic [15:0] GOLD_B = model_sig(SEED_B, LIM, 0);
    localparam logic [15:0] GOLD_N = model_sig(SEED_A, LIMOFF, 0);
    localparam logic [15:0] GOLD_F = model_sig(SEED_A, LIM, 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy_a, done_a, pass_a;
    logic busy_b, done_b, pass_b;
    logic busy_n, done_n, pass_n;
    logic busy_f, done_f, pass_f;
    logic [15:0] sig_a, sig_b, sig_n, sig_f;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fbt_bist #(.SEED(SEED_A), .WALK_LEN(WL), .NUM_TESTS(NT), .STALL_LIM(LIM),
               .FLIP_BIT(FB), .GOLDEN_SIG(GOLD_A), .STUCK_N1(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_a), .done(done_a),
        .pass(pass_a), .signature(sig_a));

    fbt_bist #(.SEED(SEED_B), .WALK_LEN(WL), .NUM_TESTS(NT), .STALL_LIM(LIM),
               .FLIP_BIT(FB), .GOLDEN_SIG(GOLD_B), .STUCK_N1(1'b0)) u_dut_seed (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_b), .done(done_b),
        .pass(pass_b), .signature(sig_b));

    fbt_bist #(.SEED(SEED_A), .WALK_LEN(WL), .NUM_TESTS(NT), .STALL_LIM(LIMOFF),
               .FLIP_BIT(FB), .GOLDEN_SIG(GOLD_N), .STUCK_N1(1'b0)) u_dut_nomod (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_n), .done(done_n),
        .pass(pass_n), .signature(sig_n));

    fbt_bist #(.SEED(SEED_A), .WALK_LEN(WL), .NUM_TESTS(NT), .STALL_LIM(LIM),
               .FLIP_BIT(FB), .GOLDEN_SIG(GOLD_A), .STUCK_N1(1'b1)) u_dut_flt (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_f), .done(done_f),
        .pass(pass_f), .signature(sig_f));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one session; returns the edge count from the accepting edge to done.
    task automatic run_session(input bit poke_start, output int cycles);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        chk(busy_a == 1'b1, "R8 busy after start", busy_a, 1);
        while (!done_a && cycles < 2000) begin
            if (poke_start && (cycles % 7 == 3)) start = 1'b1;
            else start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
    endtask

    initial begin
        int cyc;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy_a == 1'b0, "R1 busy", busy_a, 0);
        chk(done_a == 1'b0, "R1 done", done_a, 0);
        chk(pass_a == 1'b0, "R1 pass", pass_a, 0);
        chk(sig_a == 16'h0, "R1 signature", sig_a, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy_a == 1'b0 && done_a == 1'b0, "R2 idle without start", {busy_a, done_a}, 0);

        run_session(1'b0, cyc);
        chk(cyc == LAT, "R6 R8 done latency", cyc, LAT);
        chk(sig_a == GOLD_A, "R3 R4 R7 signature", sig_a, GOLD_A);
        chk(pass_a == 1'b1, "R9 pass on match", pass_a, 1);
        chk(busy_a == 1'b0, "R8 busy low at done", busy_a, 0);
        chk(sig_b == GOLD_B, "R3 second seed signature", sig_b, GOLD_B);
        chk(pass_b == 1'b1, "R9 second seed pass", pass_b, 1);
        chk(GOLD_B != GOLD_A, "R3 seeds give distinct pattern sets", GOLD_B, GOLD_A);
        chk(sig_n == GOLD_N, "R5 modifier-off signature", sig_n, GOLD_N);
        chk(GOLD_N != GOLD_A, "R5 stall flips change the walk", GOLD_N, GOLD_A);
        chk(sig_f == GOLD_F, "R10 faulty core signature", sig_f, GOLD_F);
        chk(pass_f == 1'b0, "R10 fault reported", pass_f, 0);
        chk(done_f == 1'b1, "R10 faulty run completes", done_f, 1);

        held = sig_a;
        repeat (5) @(negedge clk);
        chk(done_a == 1'b1 && sig_a == held, "R8 done and signature hold", sig_a, held);

        // Rerun with start pulses during the session, which must be ignored.
        run_session(1'b1, cyc);
        chk(cyc == LAT, "R2 start ignored while busy (latency)", cyc, LAT);
        chk(sig_a == GOLD_A, "R2 rerun from known state repeats signature", sig_a, GOLD_A);
        chk(pass_a == 1'b1, "R9 pass on rerun", pass_a, 1);

        // Reset in the middle of a session.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy_a == 1'b0 && done_a == 1'b0 && pass_a == 1'b0, "R1 mid-run reset status",
            {busy_a, done_a, pass_a}, 0);
        chk(sig_a == 16'h0, "R1 mid-run reset signature", sig_a, 0);
        rst_n = 1'b1;

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule